// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides which of six interrupt sources a small 8-bit core services next, and at which fixed address. The sources are two external active-low pins, two timer overflow events, one serial-port flag and one flag from a third timer. Each source has its own enable bit and its own priority bit. A global enable gates all of them. Each external pin can sense either a low level or a falling edge.

The core sees one request line together with the vector of the winning source. It answers with a single-cycle acknowledge when it enters the handler, and with a single-cycle return pulse when the handler ends. The block tracks which levels are in service, so a high-priority source can interrupt a low-priority handler and nothing can interrupt a high-priority one. It also clears the pending state of sources whose flags are owned here: edge-mode pins and the two timer events.

Each clock edge of the block counts as one machine cycle. The core's fetch, stack push and register file are outside this block.

Top module: `irqc_top`

## Requirements
- R1: After reset the request output is 0 and the in-service level is 0 (idle). Every enable and priority input is treated as 0 until driven, so nothing requests after reset.
- R2: A source can raise the request only when the global enable and that source's own enable are both 1. Clearing either bit withdraws the request in the same cycle.
- R3: Sources are indexed 0..5 in this order: external 0, timer 0, external 1, timer 1, serial, timer 2. While the request is high, the vector is 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R4: When several sources of the same priority are pending, the lowest index from R3 wins.
- R5: When pending sources have different priorities, a source whose priority bit is 1 (high) wins over every source whose bit is 0 (low).
- R6: While only a low-level handler is in service, the request rises for high-priority sources only. A pending low-priority source does not raise it.
- R7: While a high-level handler is in service, the request stays 0 whatever is pending.
- R8: With its type bit at 0, an external pin requests while its last sample is low. The request goes away once the pin is sampled high again, and acknowledge does not latch it.
- R9: With its type bit at 1, an external pin latches a request when one sample is high and the next is low. The request holds after the pin goes high again, and it clears in the cycle after that source is acknowledged.
- R10: A one-cycle timer 0 or timer 1 event pulse latches a request. The request clears in the cycle after that source is acknowledged.
- R11: The serial flag and the timer 2 flag are not cleared by acknowledge. They keep requesting until they are deasserted outside the block.
- R12: The in-service level output is 0 when idle, 1 when only a low handler is active, and 2 when a high handler is active. An acknowledge pushes the winner's level. A return pulse pops the most recent level, and it is ignored in a cycle that also carries an accepted acknowledge.
- R13: An acknowledge while the request is 0 changes neither the in-service level nor any pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per machine cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n | input | 2 | External request pins, active low (bit 0 = external 0) |
| ext_edge | input | 2 | Per-pin type: 0 low level, 1 falling edge |
| tmr_tick | input | 2 | One-cycle overflow events of timer 0 (bit 0) and timer 1 |
| ser_flag | input | 1 | Serial receive/transmit flag, held outside |
| t2_flag | input | 1 | Timer 2 overflow/external flag, held outside |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, indexed as in R3 |
| src_hi | input | 6 | Per-source priority, 1 = high, indexed as in R3 |
| irq_ack | input | 1 | Core accepted the request this cycle |
| irq_ret | input | 1 | Core finished the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the winning source |
| svc_lvl | output | 2 | In-service level: 0 idle, 1 low, 2 high |

## Verification
Arbitration is tried with four kinds of pending set: every source pending at the same level, which shows the fixed polling order; a mix of high and low, which shows priority taking precedence over order; one source at a time, which shows each vector; and requests arriving while a handler runs, which separates preemption from blocking at both levels. Pin sensing is tried with a low pulse in each mode. Only a latched edge survives the pin returning high, and only a level request survives an acknowledge. Acknowledging the held serial and timer 2 flags and then returning shows that these flags do not self-clear. The timer events do clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int N_EXT  = 2;
    localparam int NSRC   = 2 * N_EXT + 2;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int SRC_SER = 2 * N_EXT;
    localparam int SRC_T2  = 2 * N_EXT + 1;

    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } svc_lvl_e;

    typedef struct packed {
        logic hi_act;
        logic lo_act;
    } svc_state_t;
endpackage

// File: rtl/irqc_pin_sense.sv
module irqc_pin_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    typedef struct packed {
        logic samp;
        logic flag;
    } sense_t;

    sense_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.samp = pin_n;
        if (clr)
            st_d.flag = 1'b0;
        if (edge_mode && st_q.samp && !pin_n)
            st_d.flag = 1'b1;
        if (!edge_mode)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.samp <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = edge_mode ? st_q.flag : !st_q.samp;
endmodule

// File: rtl/irqc_evt_latch.sv
module irqc_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr)
            pend_d = 1'b0;
        if (tick)
            pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NSRC  = 6,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  elig,
    input  logic [NSRC-1:0]  prio_hi,
    output logic             win_valid,
    output logic             win_hi,
    output logic [IDX_W-1:0] win_idx
);
    logic             hit_hi, hit_lo;
    logic [IDX_W-1:0] idx_hi, idx_lo;

    always_comb begin
        hit_hi = 1'b0;
        hit_lo = 1'b0;
        idx_hi = '0;
        idx_lo = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i] && prio_hi[i]) begin
                hit_hi = 1'b1;
                idx_hi = IDX_W'(i);
            end
            if (elig[i] && !prio_hi[i]) begin
                hit_lo = 1'b1;
                idx_lo = IDX_W'(i);
            end
        end
        win_valid = hit_hi || hit_lo;
        win_hi    = hit_hi;
        win_idx   = hit_hi ? idx_hi : idx_lo;
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [irqc_pkg::N_EXT-1:0] ext_n,
    input  logic [irqc_pkg::N_EXT-1:0] ext_edge,
    input  logic [irqc_pkg::N_EXT-1:0] tmr_tick,
    input  logic                      ser_flag,
    input  logic                      t2_flag,
    input  logic                      glb_en,
    input  logic [irqc_pkg::NSRC-1:0] src_en,
    input  logic [irqc_pkg::NSRC-1:0] src_hi,
    input  logic                      irq_ack,
    input  logic                      irq_ret,
    output logic                      irq_req,
    output logic [VEC_W-1:0]          irq_vec,
    output logic [1:0]                svc_lvl
);
    import irqc_pkg::*;

    logic [NSRC-1:0]  raw_req, elig, clr_vec;
    logic             win_valid, win_hi, take;
    logic [IDX_W-1:0] win_idx;
    svc_state_t       svc_d, svc_q;

    for (genvar p = 0; p < N_EXT; p++) begin : g_ext
        irqc_pin_sense u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[p]),
            .edge_mode (ext_edge[p]),
            .clr       (clr_vec[2*p]),
            .req       (raw_req[2*p])
        );
        irqc_evt_latch u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tmr_tick[p]),
            .clr   (clr_vec[2*p+1]),
            .pend  (raw_req[2*p+1])
        );
    end

    assign raw_req[SRC_SER] = ser_flag;
    assign raw_req[SRC_T2]  = t2_flag;
    assign elig = glb_en ? (raw_req & src_en) : '0;

    irqc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .elig      (elig),
        .prio_hi   (src_hi),
        .win_valid (win_valid),
        .win_hi    (win_hi),
        .win_idx   (win_idx)
    );

    always_comb begin
        svc_d   = svc_q;
        irq_req = win_valid && !svc_q.hi_act && (win_hi || !svc_q.lo_act);
        take    = irq_req && irq_ack;
        clr_vec = '0;
        if (take) begin
            clr_vec[win_idx] = 1'b1;
            if (win_hi) svc_d.hi_act = 1'b1;
            else        svc_d.lo_act = 1'b1;
        end else if (irq_ret) begin
            if (svc_q.hi_act) svc_d.hi_act = 1'b0;
            else              svc_d.lo_act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    assign irq_vec = irq_req ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP))
                             : '0;
    assign svc_lvl = svc_q.hi_act ? LVL_HIGH : (svc_q.lo_act ? LVL_LOW : LVL_IDLE);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      glb_en,
    input logic [irqc_pkg::NSRC-1:0] src_hi,
    input logic                      irq_ack,
    input logic                      irq_ret,
    input logic                      irq_req,
    input logic [VEC_W-1:0]          irq_vec,
    input logic [1:0]                svc_lvl
);
    import irqc_pkg::*;

    int unsigned vec_idx;
    assign vec_idx = int'(irq_vec - VEC_W'(VEC_BASE)) / VEC_STEP;

    a_r1_lvl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        svc_lvl != 2'd3);

    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glb_en);

    a_r3_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_idx < NSRC &&
                     irq_vec == VEC_W'(VEC_BASE + int'(vec_idx) * VEC_STEP)));

    a_r6_low_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && svc_lvl == 2'd1 && vec_idx < NSRC) |-> src_hi[vec_idx]);

    a_r7_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        svc_lvl == 2'd2 |-> !irq_req);

    a_r12_push: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && svc_lvl == 2'd0) |=> svc_lvl != 2'd0);

    a_r12_pop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && svc_lvl == 2'd2) |=> svc_lvl != 2'd2);

    a_r13_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_ret) |=> $stable(svc_lvl));
endmodule

bind irqc_top irqc_checker #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_en  (glb_en),
    .src_hi  (src_hi),
    .irq_ack (irq_ack),
    .irq_ret (irq_ret),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .svc_lvl (svc_lvl)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11, ext_edge = 2'b00, tmr_tick = 2'b00;
    logic        ser_flag = 1'b0, t2_flag = 1'b0, glb_en = 1'b0;
    logic [5:0]  src_en = '0, src_hi = '0;
    logic        irq_ack = 1'b0, irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  svc_lvl;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
        .tmr_tick(tmr_tick), .ser_flag(ser_flag), .t2_flag(t2_flag),
        .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .svc_lvl(svc_lvl)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_req(input string tag, input logic r, input logic [15:0] v);
        chk({tag, " req"}, {15'd0, irq_req}, {15'd0, r});
        if (r) chk({tag, " vec"}, irq_vec, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_n = 2'b11; ext_edge = 2'b00; tmr_tick = 2'b00;
        ser_flag = 1'b0; t2_flag = 1'b0; glb_en = 1'b0; src_en = '0; src_hi = '0;
        irq_ack = 1'b0; irq_ret = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic tick(input int t);
        tmr_tick[t] = 1'b1; step(); tmr_tick = 2'b00;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 lvl", {14'd0, svc_lvl}, 16'd0);
        ser_flag = 1'b1; ext_n = 2'b00; step();
        chk_req("R1 masked", 1'b0, 16'h0);
        ser_flag = 1'b0; ext_n = 2'b11;
    endtask

    task automatic t_enable();
        do_reset();
        ser_flag = 1'b1; src_en[4] = 1'b1; #1;
        chk_req("R2 no global", 1'b0, 16'h0);
        glb_en = 1'b1; #1;
        chk_req("R2 R3 serial", 1'b1, 16'h0023);
        src_en[4] = 1'b0; #1;
        chk_req("R2 src off", 1'b0, 16'h0);
        ser_flag = 1'b0; src_en = 6'h3F; t2_flag = 1'b1; #1;
        chk_req("R3 timer2", 1'b1, 16'h002B);
        t2_flag = 1'b0; #1;
    endtask

    task automatic t_order();
        do_reset();
        glb_en = 1'b1; src_en = 6'h3F;
        ser_flag = 1'b1; t2_flag = 1'b1;
        tmr_tick = 2'b11; step(); tmr_tick = 2'b00;
        chk_req("R4 first timer0", 1'b1, 16'h000B);
        pulse_ack();
        chk("R12 low push", {14'd0, svc_lvl}, 16'd1);
        chk_req("R6 low blocked", 1'b0, 16'h0);
        pulse_ret();
        chk("R12 pop", {14'd0, svc_lvl}, 16'd0);
        chk_req("R10 timer0 cleared, timer1 next", 1'b1, 16'h001B);
        pulse_ack(); pulse_ret();
        chk_req("R4 serial next", 1'b1, 16'h0023);
        pulse_ack(); pulse_ret();
        chk_req("R11 serial held", 1'b1, 16'h0023);
        ser_flag = 1'b0; t2_flag = 1'b0; #1;
    endtask

    task automatic t_preempt();
        do_reset();
        glb_en = 1'b1; src_en = 6'h3F;
        t2_flag = 1'b1; #1;
        pulse_ack();
        chk("R12 lvl low", {14'd0, svc_lvl}, 16'd1);
        src_hi[1] = 1'b1; tick(0);
        chk_req("R6 high preempts", 1'b1, 16'h000B);
        pulse_ack();
        chk("R12 lvl high", {14'd0, svc_lvl}, 16'd2);
        src_hi[3] = 1'b1; tick(1);
        chk_req("R7 high not preempted", 1'b0, 16'h0);
        pulse_ret();
        chk("R12 pop to low", {14'd0, svc_lvl}, 16'd1);
        chk_req("R6 pending high after pop", 1'b1, 16'h001B);
        pulse_ack(); pulse_ret(); pulse_ret();
        chk("R12 pop to idle", {14'd0, svc_lvl}, 16'd0);
        chk_req("R11 timer2 held", 1'b1, 16'h002B);
        t2_flag = 1'b0; #1;
    endtask

    task automatic t_hi_wins();
        do_reset();
        glb_en = 1'b1; src_en = 6'h3F; src_hi[3] = 1'b1;
        ext_n[0] = 1'b0; tick(1);
        chk_req("R5 high timer1 over ext0", 1'b1, 16'h001B);
        ext_n[0] = 1'b1;
    endtask

    task automatic t_level();
        do_reset();
        glb_en = 1'b1; src_en = 6'h3F;
        ext_n[1] = 1'b0; step();
        chk_req("R8 level low", 1'b1, 16'h0013);
        ext_n[1] = 1'b1; step();
        chk_req("R8 level released", 1'b0, 16'h0);
    endtask

    task automatic t_edge();
        do_reset();
        glb_en = 1'b1; src_en = 6'h3F; ext_edge[0] = 1'b1;
        ext_n[0] = 1'b0; step();
        chk_req("R9 edge latched", 1'b1, 16'h0003);
        ext_n[0] = 1'b1; step();
        chk_req("R9 edge held", 1'b1, 16'h0003);
        pulse_ack(); pulse_ret();
        chk_req("R9 edge cleared", 1'b0, 16'h0);
    endtask

    task automatic t_ack_idle();
        do_reset();
        glb_en = 1'b1; src_en = 6'h3F;
        pulse_ack();
        chk("R13 ack ignored", {14'd0, svc_lvl}, 16'd0);
        chk_req("R13 still quiet", 1'b0, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_order();
        t_preempt();
        t_hi_wins();
        t_level();
        t_edge();
        t_ack_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule